// File: doc/BRIEF.md
# Dual-Channel Cosine Tone Generator

This block is a direct digital synthesis tone source that feeds two 8-bit DAC code outputs. A 16-bit phase accumulator adds a programmable step on every clock of the generator clock. The top eight phase bits index a 256-entry signed cosine table. The output frequency is therefore step × f_clk / 65536.

Each channel shapes the shared cosine sample in its own way. It can attenuate the sample by a power of two, negate it for a 180-degree phase, add a signed DC offset around midscale and clamp the result to the 0..255 code range. A channel outputs either this tone or a static code written by software. Writing a static code takes the channel out of tone mode.

All settings live in a small write-only register port. Reset is asserted asynchronously and released synchronously through a two-flop synchroniser.

Top module: `tone_dds_top`

## Requirements
- R1: While reset is asserted, and after it is released with no register written, both codes are 0 and every setting is cleared (tone off, step 0, offset 0, static code 0).
- R2: A write with `wr_en` high stores `wr_data` at `wr_addr`, using this map:
  - 0: bit 0 is the global tone enable.
  - 1: the 16-bit step.
  - Channel c uses addresses 2+3c, 3+3c and 4+3c:
    - 2+3c (config): bit 0 is the tone enable, bits 2:1 the scale, bit 3 the inversion.
    - 3+3c: the signed 8-bit offset.
    - 4+3c: the static code.
  - A write to any other address changes nothing.
- R3: While the global enable is high, the phase advances by the step every clock, modulo 65536. While it is low, the phase is held at zero. A tone therefore repeats every 65536/step clocks.
- R4: The cosine sample for table index i (the top eight phase bits) is computed from p = (i+64) mod 256 and h = p mod 128.
  - The magnitude is floor(127·h·(128−h)/4096).
  - The sample is negative when p ≥ 128.
  - This gives +127 at i=0 and −127 at i=128.
- R5: The scale field s shifts the signed sample arithmetically right by s bits.
- R6: When the inversion bit is set, the scaled sample is negated. Two channels that differ only in this bit produce codes that sum to 256.
- R7: A channel in tone mode outputs clamp(128 + offset ± scaled sample) to the range 0..255, and never wraps.
- R8: While the global enable is low, a channel in tone mode outputs clamp(128 + offset).
- R9: A write to a channel's static-code address clears that channel's tone enable. From the next clock on, the channel outputs the static code.
- R10: Each code is registered and reflects the state before the clock edge that loads it. A write to one channel never changes the other channel's code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Generator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| dac_code_o | output | 16 | Channel 0 code in bits 7:0, channel 1 code in bits 15:8 |

## Verification
The assertions check the following every cycle:
- the phase stays at zero while the generator is idle and advances by exactly the step while it is running;
- a static-code write clears tone mode, and a channel out of tone mode repeats its static code;
- an idle tone channel with zero offset sits at code 128.

Only the bench's scenarios can show the rest. The waveform period must match 65536/step, and the scaled peaks must land at 143 and 112. Inverted and plain channels must mirror about 128. With extreme offsets the codes must stop at 0 and 255 instead of wrapping. A write to one channel or to an unmapped address must leave the other output alone.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int CODE_W = 8;
  localparam int IDX_W  = 8;
  localparam int SMP_W  = 8;
  localparam int CODE_MAX = (1 << CODE_W) - 1;
  localparam int MID_CODE = 1 << (CODE_W - 1);

  localparam int A_GLOBAL  = 0;
  localparam int A_STEP    = 1;
  localparam int CH_BASE   = 2;
  localparam int CH_STRIDE = 3;

  // quarter-shifted parabolic cosine, peak 127
  function automatic logic signed [SMP_W-1:0] cos_sample(input logic [IDX_W-1:0] idx);
    logic [IDX_W-1:0] p;
    int h;
    int mag;
    p   = idx + IDX_W'(64);
    h   = int'(p[IDX_W-2:0]);
    mag = (127 * h * (128 - h)) / 4096;
    return p[IDX_W-1] ? $signed(SMP_W'(-mag)) : $signed(SMP_W'(mag));
  endfunction
endpackage

// File: rtl/tone_phase_acc.sv
module tone_phase_acc
  import tone_pkg::*;
#(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [ACC_W-1:0] step_i,
  output logic [IDX_W-1:0] idx_o
);
  logic [ACC_W-1:0] acc_q, acc_d;

  always_comb begin
    acc_d = en_i ? acc_q + step_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

  assign idx_o = acc_q[ACC_W-1 -: IDX_W];

  // R3: idle generator keeps phase at zero
  p_hold_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> acc_q == '0);
  // R3: running generator advances by the step
  p_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> acc_q == ACC_W'($past(acc_q) + $past(step_i)));
endmodule

// File: rtl/tone_cos_rom.sv
module tone_cos_rom
  import tone_pkg::*;
(
  input  logic [IDX_W-1:0]        idx_i,
  output logic signed [SMP_W-1:0] sample_o
);
  localparam int DEPTH = 1 << IDX_W;
  logic signed [SMP_W-1:0] lut [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_lut
    assign lut[g] = cos_sample(IDX_W'(g));
  end

  assign sample_o = lut[idx_i];
endmodule

// File: rtl/tone_channel.sv
module tone_channel
  import tone_pkg::*;
#(
  parameter int               ADDR_W = 4,
  parameter logic [ADDR_W-1:0] BASE  = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [7:0]              wr_byte_i,
  input  logic                    gen_en_i,
  input  logic signed [SMP_W-1:0] sample_i,
  output logic [CODE_W-1:0]       code_o
);
  localparam logic [ADDR_W-1:0] A_CFG  = BASE;
  localparam logic [ADDR_W-1:0] A_OFF  = ADDR_W'(BASE + 1);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BASE + 2);
  localparam int SUM_W = CODE_W + 3;

  logic              tone_q, tone_d, inv_q, inv_d;
  logic [1:0]        scale_q, scale_d;
  logic [7:0]        off_q, off_d;
  logic [CODE_W-1:0] stat_q, stat_d, code_q, code_d;
  logic              hit_cfg, hit_off, hit_stat;
  logic signed [SMP_W-1:0] s_raw, s_scl;
  logic signed [SUM_W-1:0] term, sum;

  assign hit_cfg  = wr_en_i && (wr_addr_i == A_CFG);
  assign hit_off  = wr_en_i && (wr_addr_i == A_OFF);
  assign hit_stat = wr_en_i && (wr_addr_i == A_STAT);

  always_comb begin
    tone_d = tone_q; scale_d = scale_q; inv_d = inv_q;
    off_d = off_q; stat_d = stat_q;
    if (hit_cfg) begin
      tone_d  = wr_byte_i[0];
      scale_d = wr_byte_i[2:1];
      inv_d   = wr_byte_i[3];
    end
    if (hit_off) off_d = wr_byte_i;
    if (hit_stat) begin
      stat_d = wr_byte_i[CODE_W-1:0];
      tone_d = 1'b0;
    end
  end

  always_comb begin
    s_raw = gen_en_i ? sample_i : '0;
    s_scl = s_raw >>> scale_q;
    term  = $signed({{(SUM_W-SMP_W){s_scl[SMP_W-1]}}, s_scl});
    if (inv_q) term = -term;
    sum = SUM_W'(MID_CODE) + $signed({{(SUM_W-8){off_q[7]}}, off_q}) + term;
    if (!tone_q)                    code_d = stat_q;
    else if (sum < 0)               code_d = '0;
    else if (sum > SUM_W'(CODE_MAX)) code_d = CODE_W'(CODE_MAX);
    else                            code_d = sum[CODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tone_q <= 1'b0; scale_q <= '0; inv_q <= 1'b0;
      off_q <= '0; stat_q <= '0; code_q <= '0;
    end else begin
      tone_q <= tone_d; scale_q <= scale_d; inv_q <= inv_d;
      off_q <= off_d; stat_q <= stat_d; code_q <= code_d;
    end
  end

  assign code_o = code_q;

  // R9: a static-code write drops the channel out of tone mode
  p_static_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit_stat |=> !tone_q);
  // R9: outside tone mode the code is the stored static value
  p_static_out_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tone_q |=> code_q == $past(stat_q));
  // R8: idle tone channel with zero offset sits at midscale
  p_idle_mid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (tone_q && !gen_en_i && off_q == '0) |=> code_q == CODE_W'(MID_CODE));
endmodule

// File: rtl/tone_dds_top.sv
module tone_dds_top
  import tone_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ACC_W  = 16,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [NUM_CH*CODE_W-1:0] dac_code_o
);
  logic [1:0]       rsync_q;
  logic             rst_int_n;
  logic             gen_q, gen_d;
  logic [ACC_W-1:0] step_q, step_d;
  logic [IDX_W-1:0] idx;
  logic signed [SMP_W-1:0] sample;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  always_comb begin
    gen_d  = gen_q;
    step_d = step_q;
    if (wr_en && wr_addr == ADDR_W'(A_GLOBAL)) gen_d  = wr_data[0];
    if (wr_en && wr_addr == ADDR_W'(A_STEP))   step_d = wr_data[ACC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      gen_q  <= 1'b0;
      step_q <= '0;
    end else begin
      gen_q  <= gen_d;
      step_q <= step_d;
    end
  end

  tone_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_int_n), .en_i(gen_q), .step_i(step_q), .idx_o(idx)
  );

  tone_cos_rom u_rom (.idx_i(idx), .sample_o(sample));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tone_channel #(
      .ADDR_W(ADDR_W),
      .BASE  (ADDR_W'(CH_BASE + CH_STRIDE * c))
    ) u_ch (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .wr_en_i  (wr_en),
      .wr_addr_i(wr_addr),
      .wr_byte_i(wr_data[7:0]),
      .gen_en_i (gen_q),
      .sample_i (sample),
      .code_o   (dac_code_o[c*CODE_W +: CODE_W])
    );
  end
endmodule

// File: tb/tone_dds_top_tb_top.sv
module tone_dds_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] dac;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tone_dds_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .dac_code_o(dac)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model -----------------
  function automatic int ref_cos(input int i);
    int p, h, m;
    p = (i + 64) % 256;
    h = p % 128;
    m = (127 * h * (128 - h)) / 4096;
    return (p >= 128) ? -m : m;
  endfunction

  bit m_gen; int m_step, m_acc;
  bit m_tone[2]; int m_scale[2]; bit m_inv[2]; int m_off[2]; int m_stat[2];
  logic [15:0] exp_q[$];

  function automatic int ref_code(input int c);
    int s, v;
    if (!m_tone[c]) return m_stat[c];
    s = m_gen ? ref_cos((m_acc >> 8) & 255) : 0;
    s = s >>> m_scale[c];
    if (m_inv[c]) s = -s;
    v = 128 + m_off[c] + s;
    if (v < 0) v = 0;
    if (v > 255) v = 255;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_gen = 0; m_step = 0; m_acc = 0;
      for (int c = 0; c < 2; c++) begin
        m_tone[c] = 0; m_scale[c] = 0; m_inv[c] = 0; m_off[c] = 0; m_stat[c] = 0;
      end
      exp_q.delete();
    end else begin
      int nacc;
      exp_q.push_back({8'(ref_code(1)), 8'(ref_code(0))});
      nacc = m_gen ? ((m_acc + m_step) & 16'hFFFF) : 0;
      if (wr_en) begin
        if (wr_addr == 0) m_gen = wr_data[0];
        if (wr_addr == 1) m_step = int'(wr_data);
        for (int c = 0; c < 2; c++) begin
          if (wr_addr == 4'(2 + 3*c)) begin
            m_tone[c] = wr_data[0]; m_scale[c] = int'(wr_data[2:1]); m_inv[c] = wr_data[3];
          end
          if (wr_addr == 4'(3 + 3*c)) m_off[c] = int'($signed(wr_data[7:0]));
          if (wr_addr == 4'(4 + 3*c)) begin
            m_stat[c] = int'(wr_data[7:0]); m_tone[c] = 0;
          end
        end
      end
      m_acc = nacc;
    end
  end

  // scoreboard monitor: R4 R5 R6 R7 R8 R9 R10 every cycle
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [15:0] e;
      e = exp_q.pop_front();
      chk(dac == e, "R4 R5 R6 R7 R8 R9 R10 scoreboard", int'(dac), int'(e));
    end
  end

  // ---------------- driver -----------------
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  logic [7:0] s0 [256];
  logic [7:0] s1 [256];

  task automatic grab(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s0[i] = dac[7:0];
      s1[i] = dac[15:8];
    end
  endtask

  function automatic int mx(input bit ch1, input int n);
    int r = 0;
    for (int i = 0; i < n; i++) begin
      int v = ch1 ? int'(s1[i]) : int'(s0[i]);
      if (v > r) r = v;
    end
    return r;
  endfunction

  function automatic int mn(input bit ch1, input int n);
    int r = 255;
    for (int i = 0; i < n; i++) begin
      int v = ch1 ? int'(s1[i]) : int'(s0[i]);
      if (v < r) r = v;
    end
    return r;
  endfunction

  initial begin
    int bad;
    int distinct;
    idle(3);
    chk(dac == 16'h0000, "R1 code during reset", int'(dac), 0);
    rst_n = 1'b1;
    idle(5);
    chk(dac == 16'h0000, "R1 code after reset", int'(dac), 0);

    // period 64 and inversion symmetry
    wr(4'd1, 16'h0400);
    wr(4'd2, 16'h0001);
    wr(4'd5, 16'h0009);
    wr(4'd0, 16'h0001);
    idle(3);
    grab(160);
    bad = 0;
    for (int i = 0; i < 96; i++) if (s0[i] != s0[i+64]) bad++;
    chk(bad == 0, "R3 period 64 for step 0x0400", bad, 0);
    bad = 0;
    for (int i = 0; i < 160; i++) if (int'(s0[i]) + int'(s1[i]) != 256) bad++;
    chk(bad == 0, "R6 inverted pair sums to 256", bad, 0);
    chk(mx(0, 64) == 255, "R4 full-scale peak", mx(0, 64), 255);
    chk(mn(0, 64) == 1, "R4 full-scale trough", mn(0, 64), 1);

    // period 16
    wr(4'd1, 16'h1000);
    idle(3);
    grab(64);
    bad = 0;
    for (int i = 0; i < 48; i++) if (s0[i] != s0[i+16]) bad++;
    chk(bad == 0, "R3 period 16 for step 0x1000", bad, 0);
    chk(mx(0, 16) != mn(0, 16), "R3 output not constant", mx(0, 16), mn(0, 16) + 1);

    // scale 1/8
    wr(4'd1, 16'h0400);
    wr(4'd2, 16'h0007);
    idle(3);
    grab(70);
    chk(mx(0, 70) == 143, "R5 scale 3 peak", mx(0, 70), 143);
    chk(mn(0, 70) == 112, "R5 scale 3 trough", mn(0, 70), 112);

    // saturation
    wr(4'd2, 16'h0001);
    wr(4'd3, 16'h007F);
    wr(4'd6, 16'h0080);
    idle(3);
    grab(70);
    chk(mx(0, 70) == 255, "R7 high clamp reached", mx(0, 70), 255);
    chk(mn(0, 70) >= 128, "R7 no wrap at high end", mn(0, 70), 128);
    chk(mn(1, 70) == 0, "R7 low clamp reached", mn(1, 70), 0);
    chk(mx(1, 70) <= 127, "R7 no wrap at low end", mx(1, 70), 127);

    // generator idle
    wr(4'd0, 16'h0000);
    idle(3);
    chk(dac[7:0] == 8'd255, "R8 idle ch0 clamp(128+127)", int'(dac[7:0]), 255);
    chk(dac[15:8] == 8'd0, "R8 idle ch1 clamp(128-128)", int'(dac[15:8]), 0);
    wr(4'd3, 16'h0010);
    wr(4'd6, 16'h0000);
    idle(2);
    chk(dac[7:0] == 8'd144, "R8 idle ch0 offset 16", int'(dac[7:0]), 144);
    chk(dac[15:8] == 8'd128, "R8 idle ch1 midscale", int'(dac[15:8]), 128);

    // static code overrides tone
    wr(4'd0, 16'h0001);
    wr(4'd5, 16'h0001);
    wr(4'd4, 16'h005A);
    @(negedge clk);
    chk(dac[7:0] == 8'h5A, "R9 static code one clock after write", int'(dac[7:0]), 16'h5A);
    grab(64);
    bad = 0;
    for (int i = 0; i < 64; i++) if (s0[i] != 8'h5A) bad++;
    chk(bad == 0, "R9 channel stays static", bad, 0);
    distinct = 0;
    for (int i = 1; i < 64; i++) if (s1[i] != s1[0]) distinct++;
    chk(distinct > 0, "R10 other channel keeps toning", distinct, 1);

    // cross-channel and unmapped writes
    wr(4'd6, 16'h0020);
    wr(4'd7, 16'h0033);
    idle(1);
    chk(dac[7:0] == 8'h5A, "R10 ch1 writes leave ch0", int'(dac[7:0]), 16'h5A);
    chk(dac[15:8] == 8'h33, "R9 ch1 static code", int'(dac[15:8]), 16'h33);
    wr(4'd15, 16'hFFFF);
    idle(2);
    chk(dac == 16'h335A, "R2 unmapped address ignored", int'(dac), 16'h335A);

    idle(4);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule